// File: doc/BRIEF.md
# Eight-Input Prioritized Interrupt Controller

The block collects eight interrupt request lines, ranks them, and raises one interrupt line to a host. The host sets it up and commands it over an 8-bit register port with chip select, read and write strobes and one address bit. When the host acknowledges with a single-cycle pulse, the controller moves the winning request into service. One cycle later it presents a vector byte built from a programmable base and the number of the winning input.

The ranking can be fixed, with input 0 first. It can rotate automatically, so that a serviced input drops to last place. It can also be rotated by command to a software-chosen point. In-service bits are cleared by a non-specific or a specific end-of-interrupt command, or automatically at acknowledge. Only a single controller is supported; there is no chaining of several controllers.

The host bring-up runs as a short setup state machine. The states are:
- `ST_WAIT_W1`: after reset, waits for the first setup word.
- `ST_WAIT_W2`: waits for the vector base.
- `ST_WAIT_W4`: waits for the optional mode word.
- `ST_RUN`: normal operation.

The transitions are:
- W1→W2 on a first setup word.
- W2→W4 when a mode word was announced.
- W2→RUN otherwise.
- W4→RUN on the mode word.
- Any state →W2 on a new first setup word.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, and until setup completes, INT stays low and every write other than a first setup word is ignored. The mask register reads back 0 even if a write with addr=1 was attempted.
- R2: A write with addr=0 and data bit 4 set is a first setup word, and it restarts setup from any state. Bit 3 picks level (1) or edge (0) triggering. Bit 0=1 announces a mode word. The next addr=1 write is the vector base. If announced, the addr=1 write after that is the mode word, in which bit 1=1 selects automatic end-of-interrupt. A first setup word clears mask, request and in-service registers, restores fixed order, and turns off automatic rotation.
- R3: In RUN, an addr=1 write loads the mask; bit n=1 blocks input n from raising INT. A read with addr=1 returns the mask.
- R4: In edge mode a request latches on a 0→1 input change and stays latched until acknowledged. A held-high input does not latch again until it has been low. In level mode the request register follows the input one cycle later.
- R5: INT is high exactly when some unmasked request ranks above every set in-service bit. A request of equal or lower rank than an in-service one waits.
- R6: An acknowledge pulse in RUN moves the top-ranked eligible request into service and clears its edge-mode request bit. On the following cycle it drives the vector {base[7:3], input number} with the valid flag high.
- R7: An acknowledge with no eligible request returns the vector for input 7 and changes no in-service bit.
- R8: Out of setup the order is fixed: input 0 highest, input 7 lowest.
- R9: Operation words are addr=0 writes with bits 4:3 = 00. Command bits 7:5 = 001 clear the highest-ranked in-service bit. Command 011 clears the in-service bit named by bits 2:0.
- R10: Command 101 clears the highest-ranked in-service bit and makes that input lowest. Command 111 clears the in-service bit named by bits 2:0 and makes that input lowest.
- R11: Command 110 makes the input named by bits 2:0 lowest, the others following circularly, without touching in-service bits.
- R12: With automatic end-of-interrupt, acknowledge sets no in-service bit. Command 100 turns on rotation at acknowledge, so the served input becomes lowest; command 000 turns it off.
- R13: An addr=0 write with bits 4:3 = 01 and bit 1 set selects what addr=0 reads return: bit 0=1 gives the in-service register, 0 the request register. Setup resets this selection to the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, one cycle per write |
| rd_n | input | 1 | Read strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not reading |
| irq_in | input | 8 | Interrupt request inputs |
| int_o | output | 1 | Interrupt to host |
| inta | input | 1 | Acknowledge pulse, one cycle |
| vec_o | output | 8 | Vector byte |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
A wrong rotation pointer shows up at the very next acknowledge as an unexpected input number in the low vector bits. A stuck or lost in-service bit shows up as INT staying low (or rising) at the wrong moment, one cycle after the command. A request register that latches or clears wrongly shows on INT the cycle after the input changes, and on the request-register read. Sweeping every lowest-priority setting and every single input covers each rank position at these outputs.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_W1,
        ST_WAIT_W2,
        ST_WAIT_W4,
        ST_RUN
    } pic_state_e;

    localparam logic [2:0] CMD_NS_EOI   = 3'b001;
    localparam logic [2:0] CMD_SP_EOI   = 3'b011;
    localparam logic [2:0] CMD_ROT_NS   = 3'b101;
    localparam logic [2:0] CMD_ROT_SP   = 3'b111;
    localparam logic [2:0] CMD_SET_LOW  = 3'b110;
    localparam logic [2:0] CMD_AROT_ON  = 3'b100;
    localparam logic [2:0] CMD_AROT_OFF = 3'b000;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         level_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr    <= '0;
        end else begin
            prev_q <= irq_in;
            if (clr)
                irr <= '0;
            else if (level_mode)
                irr <= irq_in;
            else
                irr <= (irr | (irq_in & ~prev_q)) & ~ack_clr;
        end
    end

    // a newly latched edge request needs the input high at the latching edge
    AST_EDGE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !level_mode |-> ((irr & ~$past(irr) & ~$past(irq_in)) == '0)); // R4
endmodule

// File: rtl/pic_rank_pick.sv
module pic_rank_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    input  logic [IW-1:0] lowest,
    output logic          hit,
    output logic [IW-1:0] win_id,
    output logic [IW-1:0] win_rank
);
    logic [IW-1:0] idx;

    // rank k belongs to input (lowest + 1 + k) mod N; rank 0 wins
    always_comb begin
        hit      = 1'b0;
        win_id   = '0;
        win_rank = '0;
        idx      = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = IW'(lowest + IW'(1) + IW'(k));
            if (bits[idx]) begin
                hit      = 1'b1;
                win_id   = idx;
                win_rank = IW'(k);
            end
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [N_IRQ-1:0] irq_in,
    output logic          int_o,
    input  logic          inta,
    output logic [DW-1:0] vec_o,
    output logic          vec_vld_o
);
    localparam int IDW = $clog2(N_IRQ);
    localparam logic [IDW-1:0] LOW_RESET = IDW'(N_IRQ - 1);

    pic_state_e st_q, st_d;

    logic [DW-1:0]    base_q;
    logic [N_IRQ-1:0] imr_q, isr_q, irr;
    logic [IDW-1:0]   low_q;
    logic             aeoi_q, arot_q, level_q, w4_q, rd_isr_q;
    logic [DW-1:0]    vec_q;
    logic             vec_vld_q;

    logic wr_ev, is_w1, in_run, ocw2, ocw3, ack_ok, grant;
    logic [2:0]       cmd;
    logic [IDW-1:0]   lvl;
    logic [N_IRQ-1:0] ack_clr, isr_set, isr_clr;

    logic             req_hit, isr_hit, int_cond;
    logic [IDW-1:0]   req_id, req_rank, isr_id, isr_rank;

    assign wr_ev  = !cs_n && !wr_n;
    assign is_w1  = wr_ev && !a0 && din[4];
    assign in_run = (st_q == ST_RUN);
    assign ocw2   = in_run && wr_ev && !a0 && !din[4] && !din[3];
    assign ocw3   = in_run && wr_ev && !a0 && !din[4] && din[3];
    assign cmd    = din[7:5];
    assign lvl    = din[IDW-1:0];
    assign ack_ok = in_run && inta;

    pic_req_latch #(.N(N_IRQ)) u_req (
        .clk(clk), .rst_n(rst_n), .clr(is_w1), .level_mode(level_q),
        .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
    );

    pic_rank_pick #(.N(N_IRQ)) u_req_pick (
        .bits(irr & ~imr_q), .lowest(low_q),
        .hit(req_hit), .win_id(req_id), .win_rank(req_rank)
    );

    pic_rank_pick #(.N(N_IRQ)) u_isr_pick (
        .bits(isr_q), .lowest(low_q),
        .hit(isr_hit), .win_id(isr_id), .win_rank(isr_rank)
    );

    assign int_cond = req_hit && (!isr_hit || (req_rank < isr_rank));
    assign grant    = ack_ok && int_cond;
    assign ack_clr  = grant ? (N_IRQ'(1) << req_id) : '0;
    assign isr_set  = aeoi_q ? '0 : ack_clr;

    always_comb begin
        isr_clr = '0;
        if (ocw2) begin
            unique case (cmd)
                CMD_NS_EOI, CMD_ROT_NS: if (isr_hit) isr_clr = N_IRQ'(1) << isr_id;
                CMD_SP_EOI, CMD_ROT_SP: isr_clr = N_IRQ'(1) << lvl;
                default:                isr_clr = '0;
            endcase
        end
    end

    // setup sequencer: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT_W1: if (is_w1) st_d = ST_WAIT_W2;
            ST_WAIT_W2: if (is_w1) st_d = ST_WAIT_W2;
                        else if (wr_ev && a0) st_d = w4_q ? ST_WAIT_W4 : ST_RUN;
            ST_WAIT_W4: if (is_w1) st_d = ST_WAIT_W2;
                        else if (wr_ev && a0) st_d = ST_RUN;
            ST_RUN:     if (is_w1) st_d = ST_WAIT_W2;
            default:    st_d = ST_WAIT_W1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WAIT_W1;
        else        st_q <= st_d;
    end

    // register file and service state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            imr_q     <= '0;
            isr_q     <= '0;
            low_q     <= LOW_RESET;
            aeoi_q    <= 1'b0;
            arot_q    <= 1'b0;
            level_q   <= 1'b0;
            w4_q      <= 1'b0;
            rd_isr_q  <= 1'b0;
            vec_q     <= '0;
            vec_vld_q <= 1'b0;
        end else if (is_w1) begin
            imr_q     <= '0;
            isr_q     <= '0;
            low_q     <= LOW_RESET;
            aeoi_q    <= 1'b0;
            arot_q    <= 1'b0;
            level_q   <= din[3];
            w4_q      <= din[0];
            rd_isr_q  <= 1'b0;
            vec_vld_q <= 1'b0;
        end else begin
            if (st_q == ST_WAIT_W2 && wr_ev && a0) base_q <= din;
            if (st_q == ST_WAIT_W4 && wr_ev && a0) aeoi_q <= din[1];
            if (in_run && wr_ev && a0)             imr_q  <= din;
            if (ocw3 && din[1])                    rd_isr_q <= din[0];
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (grant && aeoi_q && arot_q) low_q <= req_id;
            if (ocw2) begin
                unique case (cmd)
                    CMD_ROT_NS:  if (isr_hit) low_q <= isr_id;
                    CMD_ROT_SP,
                    CMD_SET_LOW: low_q  <= lvl;
                    CMD_AROT_ON: arot_q <= 1'b1;
                    CMD_AROT_OFF: arot_q <= 1'b0;
                    default: ;
                endcase
            end
            vec_vld_q <= ack_ok;
            if (ack_ok)
                vec_q <= {base_q[DW-1:IDW], grant ? req_id : IDW'(N_IRQ - 1)};
        end
    end

    // outputs
    always_comb begin
        int_o     = in_run && int_cond;
        vec_o     = vec_q;
        vec_vld_o = vec_vld_q;
        dout      = '0;
        if (!cs_n && !rd_n)
            dout = a0 ? imr_q : (rd_isr_q ? isr_q : irr);
    end

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((irr & ~imr_q) != '0)); // R3
    AST_ISR_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1); // R6
    AST_ISR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q & ~$past(isr_q)) != '0) |-> $past(inta)); // R6
    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> $past(inta)); // R6
    AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (vec_o[DW-1:IDW] == base_q[DW-1:IDW])); // R6
endmodule

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0, inta = 1'b0;
    logic [7:0] din = '0, irq = '0;
    logic [7:0] dout, vec_o;
    logic       int_o, vec_vld_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pic8_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .a0(a0), .din(din), .dout(dout), .irq_in(irq), .int_o(int_o),
        .inta(inta), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; a0 = addr; din = d;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic addr, output logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; a0 = addr;
        #1 d = dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic rd_isr(output logic [7:0] d);
        wr(1'b0, 8'h0B); rd(1'b0, d);
    endtask

    task automatic rd_irr(output logic [7:0] d);
        wr(1'b0, 8'h0A); rd(1'b0, d);
    endtask

    // ack: returns vector, checks the valid flag
    task automatic ack(input string tag, input logic [7:0] exp);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        chk({tag, " vld"}, {7'd0, vec_vld_o}, 8'h01);
        chk(tag, vec_o, exp);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq = v;
        @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] w1, input logic [7:0] base);
        wr(1'b0, w1); wr(1'b1, base);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, ignored writes before setup
        chk("R1 int after reset", {7'd0, int_o}, 8'h00);
        wr(1'b1, 8'hAA);
        rd(1'b1, r); chk("R1 mask write ignored before setup", r, 8'h00);
        set_irq(8'h01);
        chk("R1 int low before setup", {7'd0, int_o}, 8'h00);
        set_irq(8'h00);

        // R2: setup without mode word, edge, base 0x20
        setup(8'h10, 8'h20);
        rd(1'b1, r); chk("R2 mask clear after setup", r, 8'h00);

        // R8/R6: every single input in fixed order
        for (int n = 0; n < 8; n++) begin
            set_irq(8'h01 << n);
            chk("R5 int on single request", {7'd0, int_o}, 8'h01);
            ack("R6 vector single", 8'h20 | 8'(n));
            rd_isr(r); chk("R6 isr after ack", r, 8'h01 << n);
            rd_irr(r); chk("R6 edge irr cleared by ack", r, 8'h00);
            wr(1'b0, 8'h20);
            rd_isr(r); chk("R9 non-specific eoi", r, 8'h00);
            set_irq(8'h00);
        end

        // R8/R5: all inputs at once, served in fixed order
        set_irq(8'hFF);
        for (int k = 0; k < 8; k++) begin
            ack("R8 fixed order", 8'h20 | 8'(k));
            chk("R5 lower requests wait", {7'd0, int_o}, 8'h00);
            wr(1'b0, 8'h20);
        end
        set_irq(8'h00);

        // R5/R9: preemption and specific eoi
        set_irq(8'h20);
        ack("R6 vector in5", 8'h25);
        set_irq(8'h24);
        chk("R5 higher preempts", {7'd0, int_o}, 8'h01);
        ack("R5 preempting vector", 8'h22);
        set_irq(8'h64);
        chk("R5 lower blocked", {7'd0, int_o}, 8'h00);
        rd_isr(r); chk("R5 nested isr", r, 8'h24);
        wr(1'b0, 8'h65);
        rd_isr(r); chk("R9 specific eoi level5", r, 8'h04);
        wr(1'b0, 8'h20);
        rd_isr(r); chk("R9 non-specific eoi", r, 8'h00);
        chk("R5 waiting request released", {7'd0, int_o}, 8'h01);
        ack("R5 released vector", 8'h26);
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R3: mask
        wr(1'b1, 8'h7F);
        rd(1'b1, r); chk("R3 mask readback", r, 8'h7F);
        set_irq(8'h01);
        chk("R3 masked input no int", {7'd0, int_o}, 8'h00);
        set_irq(8'h81);
        chk("R3 unmasked input int", {7'd0, int_o}, 8'h01);
        ack("R3 vector unmasked", 8'h27);
        wr(1'b0, 8'h20);
        wr(1'b1, 8'h00);
        chk("R3 unmask releases latched", {7'd0, int_o}, 8'h01);
        ack("R3 vector after unmask", 8'h20);
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R4: held-high input latches once
        set_irq(8'h08);
        ack("R4 first edge", 8'h23);
        wr(1'b0, 8'h20);
        repeat (2) @(negedge clk);
        chk("R4 held high no relatch int", {7'd0, int_o}, 8'h00);
        rd_irr(r); chk("R4 held high irr", r, 8'h00);
        set_irq(8'h00);
        set_irq(8'h08);
        chk("R4 relatch after low", {7'd0, int_o}, 8'h01);
        ack("R4 second edge", 8'h23);
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R7: acknowledge with nothing pending
        ack("R7 spurious vector", 8'h27);
        rd_isr(r); chk("R7 isr untouched", r, 8'h00);

        // R11: set lowest priority, sweep all positions
        for (int l = 0; l < 8; l++) begin
            setup(8'h10, 8'h20);
            wr(1'b0, 8'hC0 | 8'(l));
            set_irq(8'h00);
            set_irq(8'hFF);
            ack("R11 set-lowest winner", 8'h20 | 8'((l + 1) % 8));
            rd_isr(r); chk("R11 isr bit", r, 8'h01 << ((l + 1) % 8));
        end
        set_irq(8'h00);

        // R10: rotate on eoi
        setup(8'h10, 8'h20);
        set_irq(8'hFF);
        ack("R10 first", 8'h20);
        wr(1'b0, 8'hA0);
        rd_isr(r); chk("R10 rotate ns clears", r, 8'h00);
        ack("R10 after rotate ns", 8'h21);
        wr(1'b0, 8'hE6);
        chk("R10 rotate sp makes 7 outrank", {7'd0, int_o}, 8'h01);
        ack("R10 after rotate sp", 8'h27);
        rd_isr(r); chk("R10 isr two set", r, 8'h82);
        wr(1'b0, 8'h20);
        rd_isr(r); chk("R10 ns eoi uses rotated rank", r, 8'h02);
        set_irq(8'h00);

        // R4: level mode, R2 trigger bit
        setup(8'h18, 8'h40);
        set_irq(8'h10);
        chk("R4 level int", {7'd0, int_o}, 8'h01);
        rd_irr(r); chk("R4 level irr follows", r, 8'h10);
        set_irq(8'h00);
        rd_irr(r); chk("R4 level irr drops", r, 8'h00);
        chk("R4 level int drops", {7'd0, int_o}, 8'h00);

        // R12: automatic eoi with rotation, R2 mode word
        wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h02);
        set_irq(8'h40);
        ack("R12 aeoi vector", 8'h86);
        rd_isr(r); chk("R12 aeoi no isr", r, 8'h00);
        set_irq(8'h00);
        wr(1'b0, 8'h80);
        set_irq(8'hFF);
        ack("R12 arot 0", 8'h80);
        ack("R12 arot 1", 8'h81);
        ack("R12 arot 2", 8'h82);
        wr(1'b0, 8'h00);
        ack("R12 arot off 3", 8'h83);
        ack("R12 arot off 4", 8'h84);
        set_irq(8'h00);

        // R2/R13: restart mid-operation
        setup(8'h10, 8'h20);
        wr(1'b1, 8'h0F);
        set_irq(8'h10);
        ack("R2 pre-restart", 8'h24);
        wr(1'b0, 8'h10);
        rd(1'b1, r); chk("R2 restart clears mask", r, 8'h00);
        rd(1'b0, r); chk("R13 restart selects irr", r, 8'h00);
        chk("R2 int low during setup", {7'd0, int_o}, 8'h00);
        wr(1'b1, 8'h20);
        rd_isr(r); chk("R2 restart clears isr", r, 8'h00);
        set_irq(8'h00);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule